// File: doc/BRIEF.md
# Field-Mode Register Bank

This block is a memory-mapped slave with a fixed set of register fields behind a 32-bit, word-addressed bus. Each address holds exactly one field and one access mode. The mode decides which bus operations the field accepts and what side effect a read or write causes. The modes are read/write, read-only, write-only, clear-on-read and strobe-on-write. The surrounding logic sees every stored field on its own output port at the same time. Read-only values come in on input ports.

A field narrower than 32 bits still uses a whole address. When read, its unused upper bits return as zeros or as copies of the field's top bit, chosen per field by a parameter. The bank occupies `NUM_ADDR*4` bytes of address space.

A wide counter input (64 bits by default) spans consecutive addresses. Reading its low word freezes the remaining upper words in a holding register, so a later read of the upper words returns the same sample as the low word.

Top module: `fieldbank_top`

## Requirements
- R1: A read strobe sampled on a rising edge yields `busRdValid` high and the read value on `busRdata` in the following cycle. `busRdata` is zero in any cycle that does not follow a read.
- R2: After reset, the stored fields hold their default values: `ctrlOut`=`CTRL_RST` (0x5A5), `trimOut`=`TRIM_RST` (0x3F0), and `cmdOut`, `evtOut` and `pulseOut` are zero.
- R3: Address 0 (control, 12 bits, unsigned) and address 1 (trim, 10 bits, signed) are read/write. A write updates the output in the cycle after the write, and a read returns the stored value.
- R4: A narrow field reads back zero-extended when declared unsigned and sign-extended when declared signed. Trim (address 1) and level (address 3) are signed; control (address 0) and status (address 2) are unsigned.
- R5: Addresses 2 (`statusIn`) and 3 (`levelIn`) are read-only. A read returns the input value present on the read cycle, and writes to these addresses change nothing.
- R6: Address 4 is write-only. A write stores the low 16 bits on `cmdOut`, and a read returns zero.
- R7: Address 5 is clear-on-read. Bits raised on `evtSet` accumulate in `evtOut`. A read returns the accumulated value, and the field is zero in the next cycle. Writes are ignored.
- R8: An `evtSet` bit that is high in the same cycle as a clearing read is kept, so the set wins over the clear.
- R9: Address 6 is strobe-on-write. A write drives its low 4 bits on `pulseOut` for exactly the one cycle after the write, then `pulseOut` returns to zero. A read returns zero.
- R10: Address 7 returns `countIn[31:0]` and captures the upper bits of `countIn`. Address 8 returns the captured bits `[63:32]`, whatever `countIn` has become since then.
- R11: Addresses 9 to 15 are unmapped. They read as zero, and writes to them change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read |
| busRdValid | output | 1 | Marks the cycle that carries read data |
| ctrlOut | output | CTRL_W | Control field |
| trimOut | output | TRIM_W | Signed trim field |
| cmdOut | output | CMD_W | Write-only command field |
| pulseOut | output | PULSE_W | One-cycle strobe field |
| evtOut | output | EVT_W | Sticky event field |
| statusIn | input | STAT_W | Read-only status value |
| levelIn | input | LVL_W | Read-only signed level value |
| evtSet | input | EVT_W | Per-bit event set requests |
| countIn | input | CNT_W | Wide counter value |

## Verification
On every cycle, the in-line assertions check these behaviours:
- read data is zero when no read preceded it;
- a read of a write-only or unmapped address returns zero;
- a clearing read empties the event field unless a set arrives in the same cycle;
- pending sets always land;
- the strobe field never persists past one cycle;
- the wide-field holding register only moves on a low-word read;
- at most one write strobe is active at a time.

Only the bench scenarios can show the rest:
- sign versus zero extension on read-back;
- reset defaults;
- that writes to read-only and unmapped addresses leave every output unchanged;
- that the upper counter word reflects the sample taken at the low-word read, not the live input.

// File: rtl/fieldbank_pkg.sv
package fieldbank_pkg;

  // Fixed field addresses; the wide counter occupies ADR_CNT upward.
  localparam int ADR_CTRL  = 0;
  localparam int ADR_TRIM  = 1;
  localparam int ADR_STAT  = 2;
  localparam int ADR_LVL   = 3;
  localparam int ADR_CMD   = 4;
  localparam int ADR_EVT   = 5;
  localparam int ADR_PULSE = 6;
  localparam int ADR_CNT   = 7;

  localparam int HI_IDX_W = 3;

  typedef enum logic [2:0] {
    MD_NONE, MD_RW, MD_RO, MD_WO, MD_COR, MD_POW
  } fieldMode_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_CTRL, SRC_TRIM, SRC_STAT, SRC_LVL, SRC_EVT, SRC_CNTLO, SRC_CNTHI
  } rdSrc_e;

  typedef struct packed {
    logic                wrCtrl;
    logic                wrTrim;
    logic                wrCmd;
    logic                wrPulse;
    logic                clrEvt;
    logic                capHold;
    logic                rdEn;
    rdSrc_e              rdSrc;
    logic [HI_IDX_W-1:0] hiIdx;
  } strobe_t;

endpackage

// File: rtl/fieldbank_ctrl.sv
module fieldbank_ctrl
  import fieldbank_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           st,
  output logic              rdValid
);

  localparam int CNT_LAST = ADR_CNT + CNT_WORDS - 1;

  fieldMode_e mode;
  int         addrInt;

  assign addrInt = int'(busAddr);

  // One access mode per address.
  always_comb begin
    if (addrInt == ADR_CTRL || addrInt == ADR_TRIM)         mode = MD_RW;
    else if (addrInt == ADR_STAT || addrInt == ADR_LVL)     mode = MD_RO;
    else if (addrInt == ADR_CMD)                            mode = MD_WO;
    else if (addrInt == ADR_EVT)                            mode = MD_COR;
    else if (addrInt == ADR_PULSE)                          mode = MD_POW;
    else if (addrInt >= ADR_CNT && addrInt <= CNT_LAST)     mode = MD_RO;
    else                                                    mode = MD_NONE;
  end

  always_comb begin
    logic canWr, canRd;
    st       = '0;
    st.rdSrc = SRC_NONE;
    canWr    = busWr && (mode == MD_RW || mode == MD_WO || mode == MD_POW);
    canRd    = busRd && (mode == MD_RW || mode == MD_RO || mode == MD_COR);
    st.rdEn  = busRd;
    st.wrCtrl  = canWr && addrInt == ADR_CTRL;
    st.wrTrim  = canWr && addrInt == ADR_TRIM;
    st.wrCmd   = canWr && addrInt == ADR_CMD;
    st.wrPulse = canWr && addrInt == ADR_PULSE;
    st.clrEvt  = canRd && mode == MD_COR;
    st.capHold = canRd && addrInt == ADR_CNT;
    if (canRd) begin
      if (addrInt == ADR_CTRL)       st.rdSrc = SRC_CTRL;
      else if (addrInt == ADR_TRIM)  st.rdSrc = SRC_TRIM;
      else if (addrInt == ADR_STAT)  st.rdSrc = SRC_STAT;
      else if (addrInt == ADR_LVL)   st.rdSrc = SRC_LVL;
      else if (addrInt == ADR_EVT)   st.rdSrc = SRC_EVT;
      else if (addrInt == ADR_CNT)   st.rdSrc = SRC_CNTLO;
      else begin
        st.rdSrc = SRC_CNTHI;
        st.hiIdx = HI_IDX_W'(addrInt - ADR_CNT - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRd;
  end

  // R3: a single address never raises two write strobes
  assert_one_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrCtrl, st.wrTrim, st.wrCmd, st.wrPulse}));

  // R1: every read strobe is answered one cycle later
  assert_rd_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);

endmodule

// File: rtl/fieldbank_dp.sv
module fieldbank_dp
  import fieldbank_pkg::*;
#(
  parameter int CTRL_W  = 12,
  parameter int TRIM_W  = 10,
  parameter int STAT_W  = 16,
  parameter int LVL_W   = 8,
  parameter int CMD_W   = 16,
  parameter int PULSE_W = 4,
  parameter int EVT_W   = 8,
  parameter int CNT_W   = 64,
  parameter bit CTRL_SIGNED = 1'b0,
  parameter bit TRIM_SIGNED = 1'b1,
  parameter bit STAT_SIGNED = 1'b0,
  parameter bit LVL_SIGNED  = 1'b1,
  parameter logic [CTRL_W-1:0] CTRL_RST = 'h5A5,
  parameter logic [TRIM_W-1:0] TRIM_RST = 'h3F0,
  parameter int CNT_WORDS = (CNT_W + 31) / 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [31:0]        busWdata,
  input  logic [STAT_W-1:0]  statusIn,
  input  logic [LVL_W-1:0]   levelIn,
  input  logic [EVT_W-1:0]   evtSet,
  input  logic [CNT_W-1:0]   countIn,
  output logic [31:0]        rdData,
  output logic [CTRL_W-1:0]  ctrlOut,
  output logic [TRIM_W-1:0]  trimOut,
  output logic [CMD_W-1:0]   cmdOut,
  output logic [PULSE_W-1:0] pulseOut,
  output logic [EVT_W-1:0]   evtOut
);

  localparam int PAD_W  = CNT_WORDS * 32;
  localparam int HOLD_W = PAD_W - 32;

  logic [CTRL_W-1:0]  ctrlReg;
  logic [TRIM_W-1:0]  trimReg;
  logic [CMD_W-1:0]   cmdReg;
  logic [PULSE_W-1:0] pulseReg;
  logic [EVT_W-1:0]   evtReg;
  logic [HOLD_W-1:0]  holdReg;
  logic [PAD_W-1:0]   cntPad;
  logic [31:0]        rdNext;
  logic [31:0]        ctrlExt, trimExt, statExt, lvlExt, evtExt;

  assign cntPad = PAD_W'(countIn);

  assign ctrlExt = CTRL_SIGNED ? 32'($signed(ctrlReg))  : 32'(ctrlReg);
  assign trimExt = TRIM_SIGNED ? 32'($signed(trimReg))  : 32'(trimReg);
  assign statExt = STAT_SIGNED ? 32'($signed(statusIn)) : 32'(statusIn);
  assign lvlExt  = LVL_SIGNED  ? 32'($signed(levelIn))  : 32'(levelIn);
  assign evtExt  = 32'(evtReg);

  always_comb begin
    case (st.rdSrc)
      SRC_CTRL:  rdNext = ctrlExt;
      SRC_TRIM:  rdNext = trimExt;
      SRC_STAT:  rdNext = statExt;
      SRC_LVL:   rdNext = lvlExt;
      SRC_EVT:   rdNext = evtExt;
      SRC_CNTLO: rdNext = cntPad[31:0];
      SRC_CNTHI: rdNext = (int'(st.hiIdx) < CNT_WORDS - 1) ?
                          holdReg[int'(st.hiIdx)*32 +: 32] : 32'h0;
      default:   rdNext = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RST;
      trimReg  <= TRIM_RST;
      cmdReg   <= '0;
      pulseReg <= '0;
      evtReg   <= '0;
      holdReg  <= '0;
      rdData   <= '0;
    end else begin
      if (st.wrCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
      if (st.wrTrim) trimReg <= busWdata[TRIM_W-1:0];
      if (st.wrCmd)  cmdReg  <= busWdata[CMD_W-1:0];
      pulseReg <= st.wrPulse ? busWdata[PULSE_W-1:0] : '0;
      evtReg   <= (st.clrEvt ? '0 : evtReg) | evtSet;
      if (st.capHold) holdReg <= cntPad[PAD_W-1:32];
      rdData   <= st.rdEn ? rdNext : 32'h0;
    end
  end

  assign ctrlOut  = ctrlReg;
  assign trimOut  = trimReg;
  assign cmdOut   = cmdReg;
  assign pulseOut = pulseReg;
  assign evtOut   = evtReg;

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> rdData == 32'h0);

  // R6 and R11: write-only and unmapped addresses read as zero
  assert_noread_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && st.rdSrc == SRC_NONE) |=> rdData == 32'h0);

  assert_cor_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrEvt && evtSet == '0) |=> evtReg == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> (evtReg & $past(evtSet)) == $past(evtSet));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrPulse |=> pulseReg == '0);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !st.capHold |=> $stable(holdReg));

endmodule

// File: rtl/fieldbank_top.sv
module fieldbank_top
  import fieldbank_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CTRL_W  = 12,
  parameter int TRIM_W  = 10,
  parameter int STAT_W  = 16,
  parameter int LVL_W   = 8,
  parameter int CMD_W   = 16,
  parameter int PULSE_W = 4,
  parameter int EVT_W   = 8,
  parameter int CNT_W   = 64,
  parameter bit CTRL_SIGNED = 1'b0,
  parameter bit TRIM_SIGNED = 1'b1,
  parameter bit STAT_SIGNED = 1'b0,
  parameter bit LVL_SIGNED  = 1'b1,
  parameter logic [CTRL_W-1:0] CTRL_RST = 'h5A5,
  parameter logic [TRIM_W-1:0] TRIM_RST = 'h3F0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busRdValid,
  output logic [CTRL_W-1:0]  ctrlOut,
  output logic [TRIM_W-1:0]  trimOut,
  output logic [CMD_W-1:0]   cmdOut,
  output logic [PULSE_W-1:0] pulseOut,
  output logic [EVT_W-1:0]   evtOut,
  input  logic [STAT_W-1:0]  statusIn,
  input  logic [LVL_W-1:0]   levelIn,
  input  logic [EVT_W-1:0]   evtSet,
  input  logic [CNT_W-1:0]   countIn
);

  localparam int CNT_WORDS  = (CNT_W + 31) / 32;
  localparam int NUM_ADDR   = ADR_CNT + CNT_WORDS;
  localparam int SPAN_BYTES = NUM_ADDR * 4;

  strobe_t st;

  fieldbank_ctrl #(.ADDR_W(ADDR_W), .CNT_WORDS(CNT_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .st(st), .rdValid(busRdValid)
  );

  fieldbank_dp #(
    .CTRL_W(CTRL_W), .TRIM_W(TRIM_W), .STAT_W(STAT_W), .LVL_W(LVL_W),
    .CMD_W(CMD_W), .PULSE_W(PULSE_W), .EVT_W(EVT_W), .CNT_W(CNT_W),
    .CTRL_SIGNED(CTRL_SIGNED), .TRIM_SIGNED(TRIM_SIGNED),
    .STAT_SIGNED(STAT_SIGNED), .LVL_SIGNED(LVL_SIGNED),
    .CTRL_RST(CTRL_RST), .TRIM_RST(TRIM_RST), .CNT_WORDS(CNT_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .statusIn(statusIn), .levelIn(levelIn), .evtSet(evtSet), .countIn(countIn),
    .rdData(busRdata), .ctrlOut(ctrlOut), .trimOut(trimOut), .cmdOut(cmdOut),
    .pulseOut(pulseOut), .evtOut(evtOut)
  );

  initial begin
    assert_map_fits_R11: assert ((1 << ADDR_W) >= NUM_ADDR && SPAN_BYTES == NUM_ADDR * 4 && CNT_W > 32);
  end

endmodule

// File: tb/fieldbank_top_bench.sv
`timescale 1ns/1ps
module fieldbank_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRdValid;
  logic [11:0] ctrlOut;
  logic [9:0]  trimOut;
  logic [15:0] cmdOut;
  logic [3:0]  pulseOut;
  logic [7:0]  evtOut;
  logic [15:0] statusIn = '0;
  logic [7:0]  levelIn = '0;
  logic [7:0]  evtSet = '0;
  logic [63:0] countIn = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  fieldbank_top u_fieldbank_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .busRdValid(busRdValid),
    .ctrlOut(ctrlOut), .trimOut(trimOut), .cmdOut(cmdOut), .pulseOut(pulseOut),
    .evtOut(evtOut), .statusIn(statusIn), .levelIn(levelIn), .evtSet(evtSet),
    .countIn(countIn)
  );

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRead(logic [3:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    busAddr = addr; busRd = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Monitor: scoreboard of read responses (R1)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busRdValid) begin
        if (expQ.size() == 0) begin
          checkEq("R1 unexpected read valid", 64'(busRdValid), 64'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checkEq(t, 64'(busRdata), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset defaults
    checkEq("R2 ctrl reset", 64'(ctrlOut), 64'h5A5);
    checkEq("R2 trim reset", 64'(trimOut), 64'h3F0);
    checkEq("R2 cmd reset", 64'(cmdOut), 64'h0);
    checkEq("R2 pulse reset", 64'(pulseOut), 64'h0);
    checkEq("R2 evt reset", 64'(evtOut), 64'h0);
    checkEq("R1 no valid when idle", 64'(busRdValid), 64'h0);
    checkEq("R1 rdata zero when idle", 64'(busRdata), 64'h0);

    doRead(4'd0, 32'h0000_05A5, "R2 read ctrl default");
    doRead(4'd1, 32'hFFFF_FFF0, "R4 read trim default sign-extended");

    // R3 read/write
    doWrite(4'd0, 32'hFFFF_F123);
    checkEq("R3 ctrl after write", 64'(ctrlOut), 64'h123);
    doRead(4'd0, 32'h0000_0123, "R3 ctrl readback zero-extended");
    doWrite(4'd1, 32'h0000_01FF);
    checkEq("R3 trim after write", 64'(trimOut), 64'h1FF);
    doRead(4'd1, 32'h0000_01FF, "R4 trim positive");
    doWrite(4'd1, 32'h0000_0200);
    doRead(4'd1, 32'hFFFF_FE00, "R4 trim negative");

    // R5 read-only
    statusIn = 16'h8001; levelIn = 8'h80;
    doRead(4'd2, 32'h0000_8001, "R5 status read unsigned");
    doRead(4'd3, 32'hFFFF_FF80, "R4 level sign-extended");
    doWrite(4'd2, 32'h1234_5678);
    doWrite(4'd3, 32'h0000_0011);
    checkEq("R5 ctrl untouched by RO write", 64'(ctrlOut), 64'h123);
    doRead(4'd2, 32'h0000_8001, "R5 status after write");
    levelIn = 8'h7F;
    doRead(4'd3, 32'h0000_007F, "R5 level positive");

    // R6 write-only
    doWrite(4'd4, 32'hABCD_1234);
    checkEq("R6 cmd after write", 64'(cmdOut), 64'h1234);
    doRead(4'd4, 32'h0, "R6 write-only reads zero");

    // R7 clear-on-read
    @(negedge clk); evtSet = 8'h05;
    @(negedge clk); evtSet = 8'h20;
    @(negedge clk); evtSet = 8'h00;
    checkEq("R7 evt accumulate", 64'(evtOut), 64'h25);
    doRead(4'd5, 32'h0000_0025, "R7 evt read");
    checkEq("R7 evt cleared", 64'(evtOut), 64'h0);
    doWrite(4'd5, 32'h0000_00FF);
    checkEq("R7 evt write ignored", 64'(evtOut), 64'h0);

    // R8 set in clear cycle wins
    @(negedge clk); evtSet = 8'h01;
    @(negedge clk);
    evtSet = 8'h80; busAddr = 4'd5; busRd = 1'b1;
    expQ.push_back(32'h0000_0001); tagQ.push_back("R8 read before concurrent set");
    @(negedge clk);
    busRd = 1'b0; evtSet = 8'h00;
    checkEq("R8 set survives clear", 64'(evtOut), 64'h80);
    doRead(4'd5, 32'h0000_0080, "R8 set value read");

    // R9 strobe-on-write
    @(negedge clk);
    busAddr = 4'd6; busWdata = 32'h0000_00FA; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    checkEq("R9 pulse present", 64'(pulseOut), 64'hA);
    @(negedge clk);
    checkEq("R9 pulse gone", 64'(pulseOut), 64'h0);
    doRead(4'd6, 32'h0, "R9 strobe reads zero");

    // R10 wide field atomic read
    countIn = 64'h1111_2222_3333_4444;
    doRead(4'd7, 32'h3333_4444, "R10 low word");
    countIn = 64'h5555_6666_7777_8888;
    doRead(4'd8, 32'h1111_2222, "R10 upper from snapshot");
    doRead(4'd7, 32'h7777_8888, "R10 low word again");
    doRead(4'd8, 32'h5555_6666, "R10 new snapshot");

    // R11 unmapped
    doRead(4'd12, 32'h0, "R11 unmapped read");
    doRead(4'd9, 32'h0, "R11 first unmapped read");
    doWrite(4'd9, 32'hFFFF_FFFF);
    doWrite(4'd15, 32'hFFFF_FFFF);
    checkEq("R11 ctrl unchanged", 64'(ctrlOut), 64'h123);
    checkEq("R11 trim unchanged", 64'(trimOut), 64'h200);
    checkEq("R11 cmd unchanged", 64'(cmdOut), 64'h1234);
    checkEq("R11 pulse quiet", 64'(pulseOut), 64'h0);

    repeat (3) @(negedge clk);
    checkEq("R1 all reads answered", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule